// File: doc/BRIEF.md
# Banked Register-Window Address Front End

This block sits between the core of a small 8-bit accumulator processor and its data RAM. The core names one of 32 registers with a 5-bit number taken from the instruction. The block turns that number into a physical RAM address and issues the read and write strobes. Registers 0 to 15 form a global region that every bank shares. Registers 16 to 31 form a window that moves to one of eight banks, and the bank is the top three bits of an 8-bit pointer register.

The pointer register is held inside the block at register number 4, and the core reads and writes it like any other register. Register number 0 holds no data of its own. It is an alias, and an access to it goes to the register the pointer names: pointer bits [4:0] give the register number and bits [7:5] give the bank. The alias may land on the pointer itself. If it lands on register 0 again, the access reaches nothing.

Every access is classed by an enumerated kind. The kinds are IDLE (no access), RAM (goes to the array), PTR (goes to the pointer) and VOID (an alias that points back at itself). The kind is set from the register number and the pointer in the same cycle. Only a pointer write changes state, and it does so at the clock edge.

Top module: `regwin_bank_addr`

## Requirements
- R1: After reset the pointer reads as 0x00. While neither core_rd nor core_wr is high, ram_re and ram_we stay low.
- R2: A direct access to register 1-3 or 5-15 drives ram_addr equal to the register number, whatever the pointer bank. Data written there reads back the same under all eight banks.
- R3: A direct access to register 16-31 drives ram_addr = 16 + 16*bank + reg[3:0], where bank = pointer[7:5]. Each bank keeps its own copy of these registers.
- R4: An access to register 0 is carried out on register pointer[4:0], using bank pointer[7:5] and the same mapping as in R2 and R3.
- R5: An access to register 0 while pointer[4:0] is 0 raises no RAM strobe. It reads as 0x00, and a write to it changes neither the RAM nor the pointer.
- R6: An access to register 4 reads or writes the pointer and raises no RAM strobe. This also holds when the access arrives through the alias with pointer[4:0] = 4.
- R7: A pointer write takes effect at the next clock edge. The access in the following cycle uses the new bank and target.
- R8: A RAM-kind access writes ram_wdata = core_wdata with ram_we high. If core_rd and core_wr are both high, only the write is done and ram_re stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the pointer |
| core_rd | input | 1 | Core read request this cycle |
| core_wr | input | 1 | Core write request this cycle |
| core_reg | input | 5 | Register number from the instruction |
| core_wdata | input | 8 | Write data from the core |
| core_rdata | output | 8 | Read data to the core, combinational |
| ram_re | output | 1 | RAM read strobe |
| ram_we | output | 1 | RAM write strobe, taken at the clock edge |
| ram_addr | output | 8 | Physical RAM address (0 to 143 used) |
| ram_wdata | output | 8 | Write data to the RAM |
| ram_rdata | input | 8 | Combinational read data from the RAM |

## Verification
The bench writes a distinct value into one banked register under each bank and then reads it back under every bank. A design that ignored the bank bits, or took them from the wrong pointer field, would return the value written last instead of each bank's own value. It also writes a global register once and reads it under all eight banks, which catches a design that banks the lower half. It covers aliases that land on the pointer, on register 0 and on banked slots, a pointer write followed at once by a banked access, and read and write raised together. A wrong build would strobe RAM for a void alias, leak the pointer write into the same cycle's access, or issue a read strobe next to a write.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    typedef enum logic [1:0] {
        KIND_IDLE = 2'd0,
        KIND_RAM  = 2'd1,
        KIND_PTR  = 2'd2,
        KIND_VOID = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/regwin_ptr.sv
module regwin_ptr #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ptr_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (wr_en)
            ptr_q <= wr_data;
    end
endmodule

// File: rtl/regwin_route.sv
module regwin_route
    import regwin_pkg::*;
#(
    parameter int REG_W   = 5,
    parameter int BANK_W  = 3,
    parameter int PHYS_W  = 8,
    parameter int IND_REG = 0,
    parameter int PTR_REG = 4
) (
    input  logic                    active,
    input  logic [REG_W-1:0]        reg_num,
    input  logic [REG_W+BANK_W-1:0] ptr,
    output acc_kind_e               kind,
    output logic [PHYS_W-1:0]       phys
);
    localparam int LOW_W    = REG_W - 1;
    localparam int GLOBAL_N = 1 << LOW_W;
    localparam int PTR_W    = REG_W + BANK_W;

    logic [REG_W-1:0]  eff;
    logic [BANK_W-1:0] bank;

    always_comb begin
        eff  = (reg_num == REG_W'(IND_REG)) ? ptr[REG_W-1:0] : reg_num;
        bank = ptr[PTR_W-1 -: BANK_W];
        if (!eff[REG_W-1])
            phys = PHYS_W'(eff[LOW_W-1:0]);
        else
            phys = PHYS_W'(GLOBAL_N) + PHYS_W'({bank, eff[LOW_W-1:0]});

        if (!active)
            kind = KIND_IDLE;
        else if (eff == REG_W'(IND_REG))
            kind = KIND_VOID;
        else if (eff == REG_W'(PTR_REG))
            kind = KIND_PTR;
        else
            kind = KIND_RAM;
    end
endmodule

// File: rtl/regwin_bank_addr.sv
module regwin_bank_addr
    import regwin_pkg::*;
#(
    parameter  int REG_W    = 5,
    parameter  int BANK_W   = 3,
    parameter  int IND_REG  = 0,
    parameter  int PTR_REG  = 4,
    localparam int DATA_W   = REG_W + BANK_W,
    localparam int LOW_W    = REG_W - 1,
    localparam int GLOBAL_N = 1 << LOW_W,
    localparam int BANK_N   = 1 << BANK_W,
    localparam int PHYS_N   = GLOBAL_N * (BANK_N + 1),
    localparam int PHYS_W   = $clog2(PHYS_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_rd,
    input  logic              core_wr,
    input  logic [REG_W-1:0]  core_reg,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] core_rdata,
    output logic              ram_re,
    output logic              ram_we,
    output logic [PHYS_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);
    acc_kind_e         kind;
    logic [DATA_W-1:0] ptr_q;
    logic              ptr_we;

    regwin_route #(
        .REG_W  (REG_W),
        .BANK_W (BANK_W),
        .PHYS_W (PHYS_W),
        .IND_REG(IND_REG),
        .PTR_REG(PTR_REG)
    ) u_route (
        .active (core_rd | core_wr),
        .reg_num(core_reg),
        .ptr    (ptr_q),
        .kind   (kind),
        .phys   (ram_addr)
    );

    regwin_ptr #(.DATA_W(DATA_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ptr_we),
        .wr_data(core_wdata),
        .ptr_q  (ptr_q)
    );

    always_comb begin
        ram_we     = 1'b0;
        ram_re     = 1'b0;
        ptr_we     = 1'b0;
        core_rdata = '0;
        ram_wdata  = core_wdata;
        unique case (kind)
            KIND_RAM: begin
                ram_we     = core_wr;
                ram_re     = core_rd & ~core_wr;
                core_rdata = ram_rdata;
            end
            KIND_PTR: begin
                ptr_we     = core_wr;
                core_rdata = ptr_q;
            end
            KIND_VOID: core_rdata = '0;
            KIND_IDLE: core_rdata = '0;
        endcase
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_rd && !core_wr) |-> (!ram_re && !ram_we)); // R1

    AST_GLOBAL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_rd || core_wr) && !core_reg[REG_W-1] && core_reg != REG_W'(IND_REG)
         && core_reg != REG_W'(PTR_REG))
        |-> ((ram_re || ram_we) && ram_addr == PHYS_W'(core_reg))); // R2

    AST_BANK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_rd || core_wr) && core_reg[REG_W-1])
        |-> (ram_addr == PHYS_W'(GLOBAL_N) + PHYS_W'(ptr_q[DATA_W-1 -: BANK_W]) * PHYS_W'(GLOBAL_N)
             + PHYS_W'(core_reg[LOW_W-1:0]))); // R3

    AST_SELF_ALIAS_VOID: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_rd || core_wr) && core_reg == REG_W'(IND_REG) && ptr_q[REG_W-1:0] == REG_W'(IND_REG))
        |-> (!ram_re && !ram_we && (!core_rd || core_rdata == '0))); // R5

    AST_PTR_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_rd || core_wr) && core_reg == REG_W'(PTR_REG)) |-> (!ram_re && !ram_we)); // R6

    AST_PTR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wr && core_reg == REG_W'(PTR_REG)) |=> (ptr_q == $past(core_wdata))); // R7
endmodule

// File: tb/tb_regwin_bank_addr.sv
module tb_regwin_bank_addr;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_N = 144;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       core_rd = 1'b0;
    logic       core_wr = 1'b0;
    logic [4:0] core_reg = '0;
    logic [7:0] core_wdata = '0;
    logic [7:0] core_rdata;
    logic       ram_re;
    logic       ram_we;
    logic [7:0] ram_addr;
    logic [7:0] ram_wdata;
    logic [7:0] ram_rdata;

    logic [7:0] mem [MEM_N];
    logic [7:0] ref_mem [MEM_N];
    logic [7:0] ref_ptr;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regwin_bank_addr dut (
        .clk(clk), .rst_n(rst_n), .core_rd(core_rd), .core_wr(core_wr),
        .core_reg(core_reg), .core_wdata(core_wdata), .core_rdata(core_rdata),
        .ram_re(ram_re), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    assign ram_rdata = (int'(ram_addr) < MEM_N) ? mem[ram_addr] : 8'hEE;

    always @(posedge clk)
        if (ram_we && int'(ram_addr) < MEM_N)
            mem[ram_addr] <= ram_wdata;

    // kinds: 0 void, 1 pointer, 2 ram
    function automatic int exp_kind(input logic [4:0] rn, input logic [7:0] p);
        logic [4:0] e;
        e = (rn == 5'd0) ? p[4:0] : rn;
        if (e == 5'd0) return 0;
        if (e == 5'd4) return 1;
        return 2;
    endfunction

    function automatic int exp_addr(input logic [4:0] rn, input logic [7:0] p);
        logic [4:0] e;
        e = (rn == 5'd0) ? p[4:0] : rn;
        if (e < 5'd16) return int'(e);
        return 16 + 16 * int'(p[7:5]) + int'(e[3:0]);
    endfunction

    function automatic string auto_req(input logic [4:0] rn, input logic [7:0] p);
        int k;
        k = exp_kind(rn, p);
        if (k == 0) return "R5";
        if (k == 1) return "R6";
        if (rn == 5'd0) return "R4";
        if (rn < 5'd16) return "R2";
        return "R3";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic rd, input logic wr, input logic [4:0] rn,
                          input logic [7:0] d, input string req_in);
        int k, a, ea, aa;
        logic ere, ewe;
        string req;
        @(negedge clk);
        core_rd = rd; core_wr = wr; core_reg = rn; core_wdata = d;
        #1;
        req = (req_in.len() > 0) ? req_in : auto_req(rn, ref_ptr);
        k = exp_kind(rn, ref_ptr);
        a = exp_addr(rn, ref_ptr);
        ere = (k == 2) && rd && !wr;
        ewe = (k == 2) && wr;
        ea = {ere, ewe, (ere || ewe) ? a[7:0] : 8'h00};
        aa = {ram_re, ram_we, (ere || ewe) ? ram_addr : 8'h00};
        check(aa == ea && (!ewe || ram_wdata == d), req, "strobes/addr", aa, ea);
        if (rd && !wr) begin
            logic [7:0] er;
            er = (k == 2) ? ref_mem[a] : (k == 1) ? ref_ptr : 8'h00;
            check(core_rdata == er, req, "rdata", int'(core_rdata), int'(er));
        end
        @(posedge clk);
        if (wr) begin
            if (k == 2) ref_mem[a] = d;
            else if (k == 1) ref_ptr = d;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < MEM_N; i++) begin
            mem[i] = 8'(i * 3);
            ref_mem[i] = 8'(i * 3);
        end
        ref_ptr = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: idle after reset
        check(!ram_re && !ram_we, "R1", "idle strobes", {ram_re, ram_we}, 0);
        access(1'b1, 1'b0, 5'd4, 8'h00, "R1");

        // R2: global register identical across banks
        access(1'b0, 1'b1, 5'd4, 8'h00, "R6");
        access(1'b0, 1'b1, 5'd9, 8'h5C, "R2");
        for (int b = 0; b < 8; b++) begin
            access(1'b0, 1'b1, 5'd4, 8'(b << 5) | 8'h07, "R7");
            access(1'b1, 1'b0, 5'd9, 8'h00, "R2");
        end
        // R3: banked isolation
        for (int b = 0; b < 8; b++) begin
            access(1'b0, 1'b1, 5'd4, 8'(b << 5), "R7");
            access(1'b0, 1'b1, 5'd20, 8'hA0 + 8'(b), "R3");
        end
        for (int b = 7; b >= 0; b--) begin
            access(1'b0, 1'b1, 5'd4, 8'(b << 5), "R6");
            access(1'b1, 1'b0, 5'd20, 8'h00, "R3");
        end
        // R4: alias into banked slot
        access(1'b0, 1'b1, 5'd4, 8'h74, "R6");
        access(1'b0, 1'b1, 5'd4, 8'h7A, "R6");
        access(1'b0, 1'b1, 5'd0, 8'h3D, "R4");
        access(1'b1, 1'b0, 5'd26, 8'h00, "R4");
        // R5: self alias is void
        access(1'b0, 1'b1, 5'd4, 8'hE0, "R6");
        access(1'b0, 1'b1, 5'd0, 8'h99, "R5");
        access(1'b1, 1'b0, 5'd0, 8'h00, "R5");
        access(1'b1, 1'b0, 5'd4, 8'h00, "R5");
        // R6: alias onto the pointer
        access(1'b0, 1'b1, 5'd4, 8'h44, "R6");
        access(1'b0, 1'b1, 5'd0, 8'h51, "R6");
        access(1'b1, 1'b0, 5'd4, 8'h00, "R6");
        // R7: new bank used the very next cycle
        access(1'b0, 1'b1, 5'd4, 8'hA0, "R7");
        access(1'b0, 1'b1, 5'd17, 8'h6B, "R7");
        access(1'b1, 1'b0, 5'd17, 8'h00, "R7");
        // R8: read and write together
        access(1'b1, 1'b1, 5'd18, 8'hC3, "R8");
        access(1'b1, 1'b0, 5'd18, 8'h00, "R8");

        for (int n = 0; n < 3000; n++) begin
            logic [1:0] op;
            logic [4:0] rn;
            op = 2'($urandom_range(0, 3));
            rn = 5'($urandom_range(0, 31));
            if ($urandom_range(0, 9) == 0) rn = 5'd4;
            access(op[0] | ~op[1], op[1], rn, 8'($urandom), "");
        end

        @(negedge clk);
        core_rd = 1'b0; core_wr = 1'b0;
        #1;
        check(!ram_re && !ram_we, "R1", "idle strobes", {ram_re, ram_we}, 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule